// File: doc/BRIEF.md
# Oscillator Frequency Window Supervisor

This block supervises an externally supplied oscillator clock by comparing it against an always-running internal reference clock. Over a fixed window of reference cycles it counts edges of the external clock. The count has to stay strictly inside a band. The lower bound is a quarter of the window length and the upper bound is four times the window length, which is the same as saying the external frequency must lie between one quarter and four times the reference frequency. A count outside that band, including a count of zero from a stopped clock, raises a sticky failure flag.

The failure flag also acts as a clock-select. While it is set, the block's clock output, which feeds the logic that would normally run from the external oscillator, is taken from the reference clock (the limp-mode clock). The changeover uses a break-before-make enable handshake, so the output never shows a shortened pulse. A watchdog forces the external branch off when that oscillator is dead and cannot finish the handshake. Software clears the flag with a one-cycle strobe. A good measurement alone never clears it.

The edge counter runs in the external clock domain and is carried into the reference domain as a Gray code through a synchronizer chain. The first window after reset serves only to prime the counters and is never judged.

Top module: `osc_freq_supervisor`

## Requirements
- R1: While `rst` is high and on the first edge after it, `osc_fail` and `limp_sel` are 0. `clk_out` is held low while reset is asserted.
- R2: Windows are WIN_CYC reference cycles long and are counted from the first rising `ref_clk` edge with `rst` low. The window that closes on edge WIN_CYC is never judged. A failure found in the window that closes on edge k·WIN_CYC becomes visible on `osc_fail` right after edge k·WIN_CYC, so for the first judged window that is edge 2·WIN_CYC.
- R3: A window count strictly between WIN_CYC/4 and 4·WIN_CYC (16 and 256 for the defaults) raises no failure.
- R4: A window count of WIN_CYC/4 or less (an external clock slower than a quarter of the reference) sets `osc_fail` and `limp_sel` to 1.
- R5: A window count of 4·WIN_CYC or more (an external clock faster than four times the reference) sets `osc_fail` and `limp_sel` to 1.
- R6: A stopped external clock (count 0) sets `osc_fail` and `limp_sel` to 1.
- R7: Once set, `osc_fail` and `limp_sel` stay 1 through later in-band windows until `fail_clr` or reset.
- R8: A `fail_clr` high at a rising `ref_clk` edge clears both outputs after that edge, unless a failing window closes on the same edge, in which case the set wins. If the fault persists, the flag returns at the next window end.
- R9: With `limp_sel` at 0, `clk_out` follows `osc_clk`. With `limp_sel` at 1, `clk_out` follows `ref_clk` within FORCE_CYC+8 reference cycles, even if `osc_clk` has stopped.
- R10: At no point are both branch enables active together. During a change of source between running clocks, `clk_out` shows no high or low pulse shorter than the shorter half-period of the two clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Internal reference clock; also the limp-mode clock |
| osc_clk | input | 1 | External oscillator clock under supervision |
| rst | input | 1 | Synchronous active-high reset, in the `ref_clk` domain |
| fail_clr | input | 1 | Write-one-to-clear strobe for the failure flag, `ref_clk` domain |
| osc_fail | output | 1 | Sticky failure status flag |
| limp_sel | output | 1 | Clock-select: 1 puts `clk_out` on the reference clock |
| clk_out | output | 1 | Glitch-free selected clock for downstream domains |

## Verification
Flag results are due on exact reference edges. A window failure shows up right after the edge that closes the window (edge 2·WIN_CYC for the first judged one), and a clear shows up right after the edge that samples the strobe. The bench keeps its own count of edges since reset. It lines each strobe up to a known window phase and queues the expected flag values for the reference edge they belong to, so each value is compared on the falling edge after that reference edge. Clock-source changes finish only after a synchronizer and a watchdog delay, so the bench waits FORCE_CYC plus a margin before it counts `clk_out` edges over a fixed span and allows one edge of tolerance. Pulse widths are measured while the source changes between running clocks.

// File: rtl/osc_sup_pkg.sv
package osc_sup_pkg;

  // Binary to reflected Gray code, zero-extended to 32 bits.
  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Reflected Gray code back to binary, zero-extended to 32 bits.
  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/osc_sup_edge_counter.sv
// Free-running edge counter in the external oscillator domain, published as Gray code.
module osc_sup_edge_counter #(
  parameter int CNT_W = 10
) (
  input  logic             osc_clk,
  input  logic             rst,
  output logic [CNT_W-1:0] gray_q
);
  import osc_sup_pkg::*;

  logic [1:0]       rst_sync;
  logic             rst_o;
  logic [CNT_W-1:0] bin_q;
  logic [CNT_W-1:0] bin_nxt;

  // Bring the reference-domain reset into this domain.
  always_ff @(posedge osc_clk) begin
    rst_sync <= {rst_sync[0], rst};
  end
  assign rst_o   = rst_sync[1];
  assign bin_nxt = bin_q + 1'b1;

  always_ff @(posedge osc_clk) begin
    if (rst_o) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_nxt;
      gray_q <= CNT_W'(to_gray(32'(bin_nxt)));
    end
  end

  // R3: the published code moves by at most one bit per edge, so a sampled value is coherent
  a_r3_gray_one_bit: assert property (@(posedge osc_clk) disable iff (rst_o)
    $countones(gray_q ^ $past(gray_q)) <= 1);

endmodule

// File: rtl/osc_sup_gray_sync.sv
// Multi-stage synchronizer for the Gray count, converted to binary on the reference side.
module osc_sup_gray_sync #(
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             ref_clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] gray_in,
  output logic [CNT_W-1:0] bin_q
);
  import osc_sup_pkg::*;

  logic [CNT_W-1:0] stg [SYNC_STAGES];

  always_ff @(posedge ref_clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) begin
        stg[i] <= '0;
      end
      bin_q <= '0;
    end else begin
      stg[0] <= gray_in;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        stg[i] <= stg[i-1];
      end
      bin_q <= CNT_W'(from_gray(32'(stg[SYNC_STAGES-1])));
    end
  end

endmodule

// File: rtl/osc_sup_window_check.sv
// Measurement window, band comparison and the sticky failure flag.
module osc_sup_window_check #(
  parameter int WIN_CYC  = 64,
  parameter int LOW_LIM  = 16,
  parameter int HIGH_LIM = 256,
  parameter int CNT_W    = 10
) (
  input  logic             ref_clk,
  input  logic             rst,
  input  logic             fail_clr,
  input  logic [CNT_W-1:0] cnt_bin,
  output logic             fail_q
);
  localparam int WIN_W = $clog2(WIN_CYC);

  logic [WIN_W-1:0] win_cnt;
  logic             tick;
  logic             armed_q;
  logic [CNT_W-1:0] prev_q;
  logic [CNT_W-1:0] delta;
  logic             too_slow;
  logic             too_fast;
  logic             bad;

  assign tick     = (win_cnt == WIN_W'(WIN_CYC - 1));
  assign delta    = cnt_bin - prev_q;
  assign too_slow = (delta <= CNT_W'(LOW_LIM));
  assign too_fast = (delta >= CNT_W'(HIGH_LIM));
  assign bad      = tick && armed_q && (too_slow || too_fast);

  always_ff @(posedge ref_clk) begin
    if (rst) begin
      win_cnt <= '0;
      armed_q <= 1'b0;
      prev_q  <= '0;
    end else begin
      win_cnt <= tick ? '0 : win_cnt + 1'b1;
      if (tick) begin
        prev_q  <= cnt_bin;
        armed_q <= 1'b1;
      end
    end
  end

  // Set has priority over the clear strobe.
  always_ff @(posedge ref_clk) begin
    if (rst) begin
      fail_q <= 1'b0;
    end else if (bad) begin
      fail_q <= 1'b1;
    end else if (fail_clr) begin
      fail_q <= 1'b0;
    end
  end

  // R2: the flag only rises at the close of a judged window
  a_r2_set_at_window_end: assert property (@(posedge ref_clk) disable iff (rst)
    $rose(fail_q) |-> $past(tick && armed_q));

  // R7: without a clear the flag cannot drop
  a_r7_sticky: assert property (@(posedge ref_clk) disable iff (rst)
    (fail_q && !fail_clr) |=> fail_q);

  // R8: a clear with no failing window on the same edge takes effect at once
  a_r8_clear: assert property (@(posedge ref_clk) disable iff (rst)
    (fail_q && fail_clr && !bad) |=> !fail_q);

endmodule

// File: rtl/osc_sup_clk_switch.sv
// Break-before-make clock selector with a forced release of a dead external branch.
module osc_sup_clk_switch #(
  parameter int FORCE_CYC = 16
) (
  input  logic ref_clk,
  input  logic osc_clk,
  input  logic rst,
  input  logic sel,
  output logic clk_out
);
  localparam int TO_W = $clog2(FORCE_CYC + 1);

  logic [TO_W-1:0] to_cnt;
  logic            force_q;
  logic            osc_en1, osc_en2;
  logic            ref_en1, ref_en2;

  // Watchdog: after FORCE_CYC cycles in limp mode, clear the external branch asynchronously.
  always_ff @(posedge ref_clk) begin
    if (rst) begin
      to_cnt  <= '0;
      force_q <= 1'b1;
    end else if (!sel) begin
      to_cnt  <= '0;
      force_q <= 1'b0;
    end else begin
      if (to_cnt != TO_W'(FORCE_CYC)) begin
        to_cnt <= to_cnt + 1'b1;
      end
      force_q <= (to_cnt == TO_W'(FORCE_CYC));
    end
  end

  // External branch enable: two falling-edge stages in its own domain.
  always_ff @(negedge osc_clk or posedge force_q) begin
    if (force_q) begin
      osc_en1 <= 1'b0;
      osc_en2 <= 1'b0;
    end else begin
      osc_en1 <= ~sel & ~ref_en2;
      osc_en2 <= osc_en1;
    end
  end

  // Reference branch enable: two falling-edge stages in the reference domain.
  always_ff @(negedge ref_clk) begin
    if (rst) begin
      ref_en1 <= 1'b0;
      ref_en2 <= 1'b0;
    end else begin
      ref_en1 <= sel & ~osc_en2;
      ref_en2 <= ref_en1;
    end
  end

  assign clk_out = (osc_clk & osc_en2) | (ref_clk & ref_en2);

  // R10: the two branches are never enabled together
  a_r10_break_before_make: assert property (@(posedge ref_clk) disable iff (rst)
    $onehot0({osc_en2, ref_en2}));

  // R9: the forced release only follows a limp-mode request (or reset)
  a_r9_force_after_limp: assert property (@(posedge ref_clk) disable iff (rst)
    force_q |-> ($past(sel) || $past(rst)));

endmodule

// File: rtl/osc_freq_supervisor.sv
module osc_freq_supervisor #(
  parameter int WIN_CYC     = 64,
  parameter int SYNC_STAGES = 2,
  parameter int FORCE_CYC   = 16
) (
  input  logic ref_clk,
  input  logic osc_clk,
  input  logic rst,
  input  logic fail_clr,
  output logic osc_fail,
  output logic limp_sel,
  output logic clk_out
);
  localparam int LOW_LIM  = WIN_CYC / 4;
  localparam int HIGH_LIM = WIN_CYC * 4;
  localparam int CNT_W    = $clog2(HIGH_LIM) + 2;

  logic [CNT_W-1:0] gray_cnt;
  logic [CNT_W-1:0] cnt_bin;
  logic             fail_q;

  osc_sup_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .osc_clk (osc_clk),
    .rst     (rst),
    .gray_q  (gray_cnt)
  );

  osc_sup_gray_sync #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .ref_clk (ref_clk),
    .rst     (rst),
    .gray_in (gray_cnt),
    .bin_q   (cnt_bin)
  );

  osc_sup_window_check #(
    .WIN_CYC  (WIN_CYC),
    .LOW_LIM  (LOW_LIM),
    .HIGH_LIM (HIGH_LIM),
    .CNT_W    (CNT_W)
  ) u_chk (
    .ref_clk  (ref_clk),
    .rst      (rst),
    .fail_clr (fail_clr),
    .cnt_bin  (cnt_bin),
    .fail_q   (fail_q)
  );

  osc_sup_clk_switch #(.FORCE_CYC(FORCE_CYC)) u_sw (
    .ref_clk (ref_clk),
    .osc_clk (osc_clk),
    .rst     (rst),
    .sel     (fail_q),
    .clk_out (clk_out)
  );

  assign osc_fail = fail_q;
  assign limp_sel = fail_q;

endmodule

// File: tb/osc_freq_supervisor_test.sv
`timescale 1ns/1ps
module osc_freq_supervisor_test;
  localparam int WIN   = 64;
  localparam int FORCE = 16;

  logic ref_clk = 1'b0;
  logic osc_clk = 1'b0;
  logic rst = 1'b1;
  logic fail_clr = 1'b0;
  logic osc_fail, limp_sel, clk_out;

  realtime osc_half = 25.0;
  bit      osc_run  = 1'b1;

  int n_checks = 0;
  int n_fail   = 0;
  int ecnt     = 0;

  always #5 ref_clk = ~ref_clk;

  always begin
    if (osc_run) #(osc_half) osc_clk = ~osc_clk;
    else #1;
  end

  osc_freq_supervisor #(.WIN_CYC(WIN), .SYNC_STAGES(2), .FORCE_CYC(FORCE)) uut (
    .ref_clk  (ref_clk),
    .osc_clk  (osc_clk),
    .rst      (rst),
    .fail_clr (fail_clr),
    .osc_fail (osc_fail),
    .limp_sel (limp_sel),
    .clk_out  (clk_out)
  );

  // Edges since reset release, matching the window numbering of R2.
  always @(posedge ref_clk) begin
    if (rst) ecnt <= 0;
    else     ecnt <= ecnt + 1;
  end

  // Scoreboard: expected flag pairs, each due right after a given reference edge.
  string tag_q[$];
  bit    f_q[$];
  bit    s_q[$];

  task automatic expect_after_edge(input string tag, input bit f, input bit s);
    @(posedge ref_clk);
    tag_q.push_back(tag);
    f_q.push_back(f);
    s_q.push_back(s);
  endtask

  always @(negedge ref_clk) begin
    while (tag_q.size() != 0) begin
      string t;
      bit    f, s;
      t = tag_q.pop_front();
      f = f_q.pop_front();
      s = s_q.pop_front();
      n_checks++;
      if (osc_fail !== f || limp_sel !== s) begin
        n_fail++;
        $display("FAIL %s: osc_fail/limp_sel = %b/%b, expected %b/%b", t, osc_fail, limp_sel, f, s);
      end
    end
  end

  task automatic chk_range(input string tag, input int got, input int lo, input int hi);
    n_checks++;
    if (got < lo || got > hi) begin
      n_fail++;
      $display("FAIL %s: got %0d, expected %0d..%0d", tag, got, lo, hi);
    end
  endtask

  // Edge counter on the output clock.
  int out_edges = 0;
  bit cnt_on = 1'b0;
  always @(posedge clk_out) if (cnt_on) out_edges++;

  task automatic count_edges(input int ncyc, output int n);
    @(negedge ref_clk);
    out_edges = 0;
    cnt_on = 1'b1;
    repeat (ncyc) @(negedge ref_clk);
    cnt_on = 1'b0;
    n = out_edges;
  endtask

  // Pulse-width monitor for R10.
  bit      meas_on   = 1'b0;
  bit      have_last = 1'b0;
  realtime last_t    = 0.0;
  realtime min_hi    = 1.0e9;
  realtime min_lo    = 1.0e9;
  always @(clk_out) begin
    if (meas_on) begin
      if (have_last) begin
        if (clk_out == 1'b0) begin
          if ($realtime - last_t < min_hi) min_hi = $realtime - last_t;
        end else begin
          if ($realtime - last_t < min_lo) min_lo = $realtime - last_t;
        end
      end
      last_t = $realtime;
      have_last = 1'b1;
    end
  end

  task automatic align(input int ph);
    @(negedge ref_clk);
    while (ecnt % WIN != ph) @(negedge ref_clk);
  endtask

  task automatic pulse_clear(input string tag);
    align(5);
    fail_clr = 1'b1;
    expect_after_edge(tag, 1'b0, 1'b0);
    @(negedge ref_clk);
    fail_clr = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge ref_clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout, expected completion");
    summary();
    $finish;
  end

  initial begin
    int n;
    // R1: reset state; external clock starts slow (50 ns, about 12 per window)
    osc_half = 25.0;
    repeat (20) @(posedge ref_clk);
    expect_after_edge("R1 flags in reset", 1'b0, 1'b0);
    @(negedge ref_clk);
    chk_range("R1 clk_out low in reset", int'(clk_out), 0, 0);
    rst = 1'b0;
    meas_on = 1'b1;
    expect_after_edge("R1 flags first edge after reset", 1'b0, 1'b0);

    // R2 / R4: the first window is not judged; the slow failure shows right after edge 2*WIN
    repeat (2*WIN - 3) @(posedge ref_clk);
    expect_after_edge("R2 no report before edge 2*WIN", 1'b0, 1'b0);
    expect_after_edge("R4 slow clock fails at edge 2*WIN", 1'b1, 1'b1);

    // R9: limp mode puts the reference clock on the output (slow clock still running)
    repeat (FORCE + 10) @(posedge ref_clk);
    count_edges(40, n);
    chk_range("R9 clk_out follows ref_clk in limp mode", n, 39, 41);

    // R7: in-band 20 ns clock does not clear the flag
    osc_half = 10.0;
    repeat (3*WIN) @(posedge ref_clk);
    expect_after_edge("R7 flag stays set after good windows", 1'b1, 1'b1);

    // R8: clear while the clock is good
    pulse_clear("R8 clear strobe drops flags");
    repeat (10) @(posedge ref_clk);
    count_edges(40, n);
    chk_range("R9 clk_out follows osc_clk after clear", n, 19, 21);
    meas_on = 1'b0;
    chk_range("R10 shortest high pulse (x0.1 ns)", int'(min_hi * 10.0), 49, 1000000);
    chk_range("R10 shortest low pulse (x0.1 ns)", int'(min_lo * 10.0), 49, 1000000);

    // R3: in-band rates near both ends stay quiet
    osc_half = 15.0;
    repeat (3*WIN) @(posedge ref_clk);
    expect_after_edge("R3 30 ns clock accepted", 1'b0, 1'b0);
    osc_half = 1.5;
    repeat (3*WIN) @(posedge ref_clk);
    expect_after_edge("R3 3 ns clock accepted", 1'b0, 1'b0);

    // R5: 2 ns clock, about 320 edges per window
    osc_half = 1.0;
    repeat (2*WIN + 2) @(posedge ref_clk);
    expect_after_edge("R5 fast clock fails", 1'b1, 1'b1);

    // R8: clear while the fault persists; the flag returns at the next window end
    pulse_clear("R8 clear with persisting fault");
    repeat (WIN - 8) @(posedge ref_clk);
    expect_after_edge("R8 stays clear until window end", 1'b0, 1'b0);
    expect_after_edge("R8 fault sets again at window end", 1'b1, 1'b1);

    // R6: return to nominal, clear, then stop the clock
    osc_half = 5.0;
    repeat (2*WIN) @(posedge ref_clk);
    pulse_clear("R8 clear at nominal rate");
    repeat (2*WIN) @(posedge ref_clk);
    expect_after_edge("R3 nominal 10 ns clock accepted", 1'b0, 1'b0);
    osc_run = 1'b0;
    repeat (2*WIN + 2) @(posedge ref_clk);
    expect_after_edge("R6 stopped clock fails", 1'b1, 1'b1);
    repeat (FORCE + 10) @(posedge ref_clk);
    count_edges(40, n);
    chk_range("R9 dead clock replaced by ref_clk", n, 39, 41);

    @(negedge ref_clk);
    @(negedge ref_clk);
    summary();
    $finish;
  end

endmodule